// File: doc/BRIEF.md
# 10BASE-T Idle Link Pulse Generator

This block sits on the transmit side of a 10 Mb/s twisted-pair physical layer. When the MAC is not sending a frame, it emits one link-pulse request for every link-test interval, which is nominally 16 ms. The request drives the analog pulse shaper. Raising transmit-enable stops the requests and clears the interval. Releasing it starts the interval again from zero, so the first pulse after a frame comes one full interval later.

Pulses keep running while the receiver is busy. They never count as transmit activity. The collision-qualify output therefore reflects only real transmit data that overlaps with receive activity.

The interval is counted in timebase ticks. A generate option picks the tick source:
- A parameter of zero takes the ticks from an external 1 MHz strobe.
- A nonzero parameter derives the ticks from the system clock with a free-running divider.

Top module: `nlp_link_pulse_gen`

## Requirements
- R1: With `tx_en_i` low and `rx_busy_i` at any level, `pulse_req_o` goes high in the clock cycle after the tick that completes `TICKS_PER_PERIOD` ticks. The count is taken since the last reset, the last pulse or the last cycle with `tx_en_i` high.
- R2: Each `pulse_req_o` assertion lasts exactly one clock cycle.
- R3: While `tx_en_i` is high, `pulse_req_o` stays low and the interval is held at zero. Ticks that arrive in a cycle with `tx_en_i` high are not counted.
- R4: `rx_busy_i` has no effect on when pulses occur.
- R5: `col_o` is high in the cycle after a cycle in which `tx_en_i` and `rx_busy_i` are both high. It is low in every other case.
- R6: A pulse emitted while `rx_busy_i` is high and `tx_en_i` is low never raises `col_o`.
- R7: Reset is synchronous. While `rst` is high, and in the cycle after it, `pulse_req_o` and `col_o` are low. The interval restarts from zero when `rst` is released.
- R8: When `TICK_DIV` is nonzero, the block makes one tick every `TICK_DIV` clocks and ignores `ext_tick_i`. Pulses are then exactly `TICK_DIV*TICKS_PER_PERIOD` clocks apart while transmit is idle. When `TICK_DIV` is zero, `ext_tick_i` is the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en_i | input | 1 | The MAC is sending frame data |
| rx_busy_i | input | 1 | Receive activity is present on the line |
| ext_tick_i | input | 1 | External 1 MHz tick strobe, one clock wide; used only when `TICK_DIV` is 0 |
| pulse_req_o | output | 1 | One-cycle request to the link pulse shaper |
| col_o | output | 1 | Collision qualify: transmit and receive overlapped in the previous cycle |

## Verification
The assertions take for granted that all inputs carry known values from the first clock edge and that `rst` is high for at least one edge before any activity. They also assume `TICKS_PER_PERIOD` is at least 2, so two ticks can never complete an interval back to back. The stimulus drives every input from time zero and holds reset for the first cycles. It keeps the tick a single-cycle strobe, with the spacing drawn between one and four clocks, which includes a tick in every cycle. Transmit bursts, receive activity and a mid-interval reset are drawn at random with a fixed seed, layered over directed idle and busy-receive stretches.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
  // 50 MHz system clock down to a 1 MHz timebase
  localparam int unsigned DEF_TICK_DIV = 50;
  // 16 ms interval at 1 us per tick
  localparam int unsigned DEF_TICKS_PER_PERIOD = 16000;

  typedef enum logic {
    TICK_FROM_PIN = 1'b0,
    TICK_FROM_DIV = 1'b1
  } tick_src_e;

  function automatic tick_src_e pick_src(input int unsigned div);
    return (div == 0) ? TICK_FROM_PIN : TICK_FROM_DIV;
  endfunction
endpackage

// File: rtl/nlp_tick_src.sv
module nlp_tick_src #(
  parameter int unsigned TICK_DIV = nlp_pkg::DEF_TICK_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_tick_i,
  output logic tick_o
);
  import nlp_pkg::*;
  localparam tick_src_e SRC  = pick_src(TICK_DIV);
  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (SRC == TICK_FROM_PIN) begin : g_pin
      assign tick_o = ext_tick_i;
    end else begin : g_div
      logic [DW-1:0] div_cnt;
      logic          tick_q;
      logic          unused_ext;
      assign unused_ext = ext_tick_i;

      always_ff @(posedge clk) begin
        if (rst) begin
          div_cnt <= '0;
          tick_q  <= 1'b0;
        end else begin
          tick_q <= (div_cnt == DW'(TICK_DIV - 1));
          if (div_cnt == DW'(TICK_DIV - 1)) div_cnt <= '0;
          else                              div_cnt <= div_cnt + 1'b1;
        end
      end
      assign tick_o = tick_q;

      if (TICK_DIV > 1) begin : g_gap
        assert_tick_gap_R8: assert property (@(posedge clk) disable iff (rst)
          tick_q |=> !tick_q);
      end
    end
  endgenerate
endmodule

// File: rtl/nlp_interval.sv
module nlp_interval #(
  parameter int unsigned TICKS_PER_PERIOD = nlp_pkg::DEF_TICKS_PER_PERIOD
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic tx_en_i,
  output logic pulse_o
);
  localparam int unsigned CW = (TICKS_PER_PERIOD > 1) ? $clog2(TICKS_PER_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          at_last;
  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tx_en_i) begin
        cnt <= '0;
      end else if (tick_i) begin
        if (at_last) begin
          cnt     <= '0;
          pulse_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  assert_hold_on_tx_R3: assert property (@(posedge clk) disable iff (rst)
    tx_en_i |=> (cnt == '0) && !pulse_o);

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/nlp_col_qual.sv
module nlp_col_qual (
  input  logic clk,
  input  logic rst,
  input  logic tx_en_i,
  input  logic rx_busy_i,
  output logic col_o
);
  always_ff @(posedge clk) begin
    if (rst) col_o <= 1'b0;
    else     col_o <= tx_en_i & rx_busy_i;
  end

  assert_col_needs_tx_R5: assert property (@(posedge clk) disable iff (rst)
    col_o |-> $past(tx_en_i));

  assert_idle_rx_no_col_R5: assert property (@(posedge clk) disable iff (rst)
    !rx_busy_i |=> !col_o);
endmodule

// File: rtl/nlp_link_pulse_gen.sv
module nlp_link_pulse_gen #(
  parameter int unsigned TICK_DIV         = nlp_pkg::DEF_TICK_DIV,
  parameter int unsigned TICKS_PER_PERIOD = nlp_pkg::DEF_TICKS_PER_PERIOD
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en_i,
  input  logic rx_busy_i,
  input  logic ext_tick_i,
  output logic pulse_req_o,
  output logic col_o
);
  logic tick;

  nlp_tick_src #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .ext_tick_i(ext_tick_i), .tick_o(tick)
  );

  nlp_interval #(.TICKS_PER_PERIOD(TICKS_PER_PERIOD)) u_interval (
    .clk(clk), .rst(rst), .tick_i(tick), .tx_en_i(tx_en_i), .pulse_o(pulse_req_o)
  );

  nlp_col_qual u_col (
    .clk(clk), .rst(rst), .tx_en_i(tx_en_i), .rx_busy_i(rx_busy_i), .col_o(col_o)
  );

  assert_pulse_col_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(pulse_req_o && col_o));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    $past(rst) |-> (!pulse_req_o && !col_o));
endmodule

// File: tb/nlp_link_pulse_gen_tb_top.sv
module nlp_link_pulse_gen_tb_top;
  localparam int unsigned T  = 8;
  localparam int unsigned DV = 3;
  localparam int unsigned T2 = 5;

  logic clk = 1'b0;
  logic rst = 1'b1, tx = 1'b0, rx = 1'b0, tk = 1'b0;
  logic pulse, col, pulse2, col2;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nlp_link_pulse_gen #(.TICK_DIV(0), .TICKS_PER_PERIOD(T)) dut_i (
    .clk(clk), .rst(rst), .tx_en_i(tx), .rx_busy_i(rx), .ext_tick_i(tk),
    .pulse_req_o(pulse), .col_o(col)
  );

  nlp_link_pulse_gen #(.TICK_DIV(DV), .TICKS_PER_PERIOD(T2)) dut_div_i (
    .clk(clk), .rst(rst), .tx_en_i(1'b0), .rx_busy_i(rx), .ext_tick_i(tk),
    .pulse_req_o(pulse2), .col_o(col2)
  );

  // reference state
  int  rcnt = 0;
  bit  exp_p = 0, exp_c = 0, last_p = 0;
  bit  p_tx = 0, p_rx = 0, p_rst = 1;
  int  cyc = 0, last2 = -1;

  function automatic string pulse_tag(bit ptx, bit prx, bit prst, bit lp, bit ep);
    if (prst) return "R7";
    if (ptx) return "R3";
    if (lp && !ep) return "R2";
    if (prx) return "R4";
    return "R1";
  endfunction

  task automatic check(string tag, string what, logic act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit t, bit x, bit k);
    @(negedge clk);
    cyc++;
    check(pulse_tag(p_tx, p_rx, p_rst, last_p, exp_p), "pulse_req", pulse, exp_p);
    check((exp_p && p_rx) ? "R6" : (p_rst ? "R7" : "R5"), "col", col, exp_c);
    // R8: divided-tick instance spacing, R7: quiet after reset
    if (p_rst) begin
      check("R7", "pulse_div", pulse2, 1'b0);
      last2 = -1;
    end else if (pulse2 === 1'b1) begin
      if (last2 >= 0) check("R8", "div spacing", (cyc - last2) == DV*T2, 1'b1);
      last2 = cyc;
    end
    last_p = exp_p;
    rst = r; tx = t; rx = x; tk = k;
    exp_p = 0;
    if (r || t) rcnt = 0;
    else if (k) begin
      if (rcnt == T-1) begin rcnt = 0; exp_p = 1; end
      else rcnt++;
    end
    exp_c = !r && t && x;
    p_tx = t; p_rx = x; p_rst = r;
  endtask

  initial begin
    process::self().srandom(32'd4242);
    // reset held (R7)
    for (int i = 0; i < 4; i++) step(1, 0, 0, i[0]);
    // idle, tick every other clock (R1, R2)
    for (int i = 0; i < 60; i++) step(0, 0, 0, i[0]);
    // idle, receiver busy (R4, R6)
    for (int i = 0; i < 60; i++) step(0, 0, 1, i[0]);
    // tick every clock, max rate (R1 corner)
    for (int i = 0; i < 40; i++) step(0, 0, i[2], 1);
    // transmit burst overlapping receive, then release (R3, R5)
    for (int i = 0; i < 20; i++) step(0, 1, i[1], 1);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1);
    // reset mid-interval (R7)
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
    step(1, 0, 1, 1);
    step(1, 1, 1, 1);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1);
    // constrained random
    begin
      int gap = 1;
      bit t = 0;
      for (int i = 0; i < 4000; i++) begin
        bit k = 0;
        gap--;
        if (gap == 0) begin k = 1; gap = 1 + int'($urandom_range(3)); end
        if ($urandom_range(99) < 3) t = ~t;
        step(($urandom_range(999) == 0), t, $urandom_range(1) == 1, k);
      end
    end
    // long idle for the divided instance (R8)
    for (int i = 0; i < 200; i++) step(0, 0, $urandom_range(1) == 1, $urandom_range(1) == 1);
    step(0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule